// File: doc/BRIEF.md
# Sampled Incremental PI DC-Link Voltage Controller

This block closes a DC-link voltage loop at a fixed control rate. A free-running pacing counter issues one control tick every `PERIOD` clocks; 5000 clocks of 50 MHz give a 100 µs cycle. While the run input is high, each tick starts one pass through a fixed sequence. The controller requests a 12-bit conversion from an external ADC front end and stores the returned code. It then runs one velocity-form PI step against a reference. Last, it presents the saturated current command as a parallel output word to a real-time simulator. It then waits for the next tick.

The four states and their transitions:
- IDLE_STOP goes to ACQUIRE on a tick while run is high.
- ACQUIRE goes to COMPUTE when the ADC reports ready, or to PUBLISH on timeout.
- COMPUTE goes to PUBLISH after one cycle.
- PUBLISH goes to ACQUIRE on the next tick.
- Every state goes to IDLE_STOP when run is low.

The gains and the output limits are signed inputs that are held steady by the surrounding logic. The gains use a fixed point with `FRAC_W` fractional bits.

Top module: `dclink_pi_ctrl`

## Requirements
- R1: After reset the block is in IDLE_STOP with `gpio_word` = 0, `adc_req` = 0 and `adc_fault` = 0.
- R2: In IDLE_STOP the block stays idle until `run_en` is high in a tick cycle, and then enters ACQUIRE.
- R3: A tick occurs once every `PERIOD` clocks from a counter that runs freely after reset. ACQUIRE is entered only on a tick, so acquisitions begin exactly `PERIOD` clocks apart.
- R4: `adc_req` is high for exactly the cycles spent in ACQUIRE. In a cycle where `adc_ready` is high, `adc_code` is stored and the next state is COMPUTE. A ready in the last cycle before the timeout still counts as a capture.
- R5: COMPUTE lasts one cycle and forms the following, with all terms signed:
  - e = v_ref − sample
  - y = y_prev + ((kp·(e − e_prev) + ki_t·e) >>> FRAC_W), where the shift is arithmetic
  - y_prev and e_prev are then replaced by the new y and e.
- R6: The new y is clamped to the range [y_min, y_max]. The clamped value is the one kept as y_prev, so windup cannot build up.
- R7: In every PUBLISH cycle, `gpio_word` is loaded with y as a two's-complement value. PUBLISH then waits for the next tick.
- R8: If ACQUIRE spends `TIMEOUT` cycles without `adc_ready`, `adc_fault` is set, COMPUTE is skipped and `gpio_word` keeps its previous value. The next successful capture clears `adc_fault`.
- R9: A low `run_en` forces IDLE_STOP on the next edge, and this takes priority over a tick. While in IDLE_STOP, y_prev, e_prev, `gpio_word` and `adc_fault` are cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| run_en | input | 1 | Start switch; high runs the loop |
| v_ref | input | 12 | Voltage reference code |
| kp | input | 16 | Proportional gain, signed, FRAC_W fraction bits |
| ki_t | input | 16 | Integral gain times sample period, signed, FRAC_W fraction bits |
| y_min | input | 16 | Lower output limit, signed |
| y_max | input | 16 | Upper output limit, signed |
| adc_ready | input | 1 | Conversion result valid |
| adc_code | input | 12 | Measured DC-link voltage code |
| adc_req | output | 1 | Conversion request, high throughout ACQUIRE |
| adc_fault | output | 1 | Last acquisition timed out |
| gpio_word | output | 16 | Current command word to the simulator |

## Verification
Two pairs of events are made to fall in the same clock cycle.

The first pair is an ADC ready and the timeout expiry. The bench delays its ADC responder so that ready arrives exactly in the final allowed ACQUIRE cycle. The reference model expects a capture, so `adc_fault` must clear and a fresh command must appear.

The second pair is a falling run switch and a control tick. The bench lowers `run_en` one cycle before a tick edge, counted from the previous rise of the request. It then judges that no request is raised and that the output word and the fault flag are cleared.

// File: rtl/dclink_pi_pkg.sv
package dclink_pi_pkg;
    typedef enum logic [1:0] {
        ST_STOP = 2'd0,
        ST_MEM  = 2'd1,
        ST_CALC = 2'd2,
        ST_OUT  = 2'd3
    } ctl_state_t;
endpackage

// File: rtl/pi_tick_gen.sv
module pi_tick_gen #(
    parameter int PERIOD = 5000
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int CNT_W = (PERIOD > 1) ? $clog2(PERIOD) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(PERIOD - 1);

    logic [CNT_W-1:0] cnt_q;

    assign tick = (cnt_q == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   cnt_q <= '0;
        else if (tick) cnt_q <= '0;
        else          cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/pi_adc_capture.sv
module pi_adc_capture #(
    parameter int SAMPLE_W = 12,
    parameter int TIMEOUT  = 150
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                active,
    input  logic                adc_ready,
    input  logic [SAMPLE_W-1:0] adc_code,
    output logic [SAMPLE_W-1:0] sample_q,
    output logic                captured,
    output logic                expired
);
    localparam int TMO_W = (TIMEOUT > 1) ? $clog2(TIMEOUT) : 1;
    localparam logic [TMO_W-1:0] TMO_LAST = TMO_W'(TIMEOUT - 1);

    logic [TMO_W-1:0] tmo_q;

    assign captured = active && adc_ready;
    assign expired  = active && !adc_ready && (tmo_q == TMO_LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tmo_q    <= '0;
            sample_q <= '0;
        end else begin
            if (!active || captured || expired) tmo_q <= '0;
            else                               tmo_q <= tmo_q + 1'b1;
            if (captured) sample_q <= adc_code;
        end
    end
endmodule

// File: rtl/pi_update.sv
module pi_update #(
    parameter int SAMPLE_W = 12,
    parameter int COEF_W   = 16,
    parameter int FRAC_W   = 8,
    parameter int OUT_W    = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     clear,
    input  logic                     step,
    input  logic [SAMPLE_W-1:0]      v_ref,
    input  logic [SAMPLE_W-1:0]      sample,
    input  logic signed [COEF_W-1:0] kp,
    input  logic signed [COEF_W-1:0] ki_t,
    input  logic signed [OUT_W-1:0]  y_min,
    input  logic signed [OUT_W-1:0]  y_max,
    output logic signed [OUT_W-1:0]  y_q
);
    localparam int E_W   = SAMPLE_W + 1;
    localparam int D_W   = SAMPLE_W + 2;
    localparam int ACC_W = COEF_W + SAMPLE_W + 4;

    logic signed [E_W-1:0]   err, e_prev_q;
    logic signed [D_W-1:0]   derr;
    logic signed [ACC_W-1:0] kp_x, ki_x, d_x, e_x, y_x, lo_x, hi_x;
    logic signed [ACC_W-1:0] acc, delta, cand;
    logic signed [OUT_W-1:0] y_next;

    assign err  = $signed({1'b0, v_ref}) - $signed({1'b0, sample});
    assign derr = {err[E_W-1], err} - {e_prev_q[E_W-1], e_prev_q};

    assign kp_x = {{(ACC_W-COEF_W){kp[COEF_W-1]}}, kp};
    assign ki_x = {{(ACC_W-COEF_W){ki_t[COEF_W-1]}}, ki_t};
    assign d_x  = {{(ACC_W-D_W){derr[D_W-1]}}, derr};
    assign e_x  = {{(ACC_W-E_W){err[E_W-1]}}, err};
    assign y_x  = {{(ACC_W-OUT_W){y_q[OUT_W-1]}}, y_q};
    assign lo_x = {{(ACC_W-OUT_W){y_min[OUT_W-1]}}, y_min};
    assign hi_x = {{(ACC_W-OUT_W){y_max[OUT_W-1]}}, y_max};

    assign acc   = kp_x * d_x + ki_x * e_x;
    assign delta = acc >>> FRAC_W;
    assign cand  = y_x + delta;

    always_comb begin
        if (cand > hi_x)      y_next = y_max;
        else if (cand < lo_x) y_next = y_min;
        else                  y_next = cand[OUT_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            y_q      <= '0;
            e_prev_q <= '0;
        end else if (clear) begin
            y_q      <= '0;
            e_prev_q <= '0;
        end else if (step) begin
            y_q      <= y_next;
            e_prev_q <= err;
        end
    end
endmodule

// File: rtl/dclink_pi_ctrl.sv
module dclink_pi_ctrl
    import dclink_pi_pkg::*;
#(
    parameter int SAMPLE_W = 12,
    parameter int COEF_W   = 16,
    parameter int FRAC_W   = 8,
    parameter int OUT_W    = 16,
    parameter int PERIOD   = 5000,
    parameter int TIMEOUT  = 150
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     run_en,
    input  logic [SAMPLE_W-1:0]      v_ref,
    input  logic signed [COEF_W-1:0] kp,
    input  logic signed [COEF_W-1:0] ki_t,
    input  logic signed [OUT_W-1:0]  y_min,
    input  logic signed [OUT_W-1:0]  y_max,
    input  logic                     adc_ready,
    input  logic [SAMPLE_W-1:0]      adc_code,
    output logic                     adc_req,
    output logic                     adc_fault,
    output logic [OUT_W-1:0]         gpio_word
);
    ctl_state_t state_q, state_d;
    logic tick, captured, expired;
    logic [SAMPLE_W-1:0] sample_q;
    logic signed [OUT_W-1:0] y_q;

    pi_tick_gen #(.PERIOD(PERIOD)) u_tick (
        .clk(clk), .rst_n(rst_n), .tick(tick)
    );

    pi_adc_capture #(.SAMPLE_W(SAMPLE_W), .TIMEOUT(TIMEOUT)) u_cap (
        .clk(clk), .rst_n(rst_n), .active(state_q == ST_MEM),
        .adc_ready(adc_ready), .adc_code(adc_code),
        .sample_q(sample_q), .captured(captured), .expired(expired)
    );

    pi_update #(.SAMPLE_W(SAMPLE_W), .COEF_W(COEF_W), .FRAC_W(FRAC_W), .OUT_W(OUT_W)) u_pi (
        .clk(clk), .rst_n(rst_n),
        .clear(state_q == ST_STOP), .step(state_q == ST_CALC),
        .v_ref(v_ref), .sample(sample_q), .kp(kp), .ki_t(ki_t),
        .y_min(y_min), .y_max(y_max), .y_q(y_q)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_STOP: if (tick) state_d = ST_MEM;
            ST_MEM: begin
                if (captured)     state_d = ST_CALC;
                else if (expired) state_d = ST_OUT;
            end
            ST_CALC: state_d = ST_OUT;
            ST_OUT:  if (tick) state_d = ST_MEM;
            default: state_d = ST_STOP;
        endcase
        if (!run_en) state_d = ST_STOP;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_STOP;
        else        state_q <= state_d;
    end

    // registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gpio_word <= '0;
            adc_fault <= 1'b0;
        end else begin
            unique case (state_q)
                ST_STOP: begin
                    gpio_word <= '0;
                    adc_fault <= 1'b0;
                end
                ST_MEM: begin
                    if (captured)     adc_fault <= 1'b0;
                    else if (expired) adc_fault <= 1'b1;
                end
                ST_OUT:  gpio_word <= $unsigned(y_q);
                default: ;
            endcase
        end
    end

    assign adc_req = (state_q == ST_MEM);
endmodule

// File: rtl/dclink_pi_chk.sv
module dclink_pi_chk
    import dclink_pi_pkg::*;
#(
    parameter int OUT_W = 16
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    run_en,
    input ctl_state_t              state_q,
    input logic                    tick,
    input logic                    adc_ready,
    input logic                    adc_req,
    input logic                    adc_fault,
    input logic signed [OUT_W-1:0] y_q,
    input logic signed [OUT_W-1:0] y_min,
    input logic signed [OUT_W-1:0] y_max,
    input logic [OUT_W-1:0]        gpio_word
);
    AST_STOP_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_STOP && !tick) |=> (state_q == ST_STOP)); // R2

    AST_REQ_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(adc_req) |-> $past(tick)); // R3

    AST_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_MEM && adc_ready && run_en) |=> (state_q == ST_CALC)); // R4

    AST_CALC_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_CALC) |=> (state_q != ST_CALC)); // R5

    AST_SAT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_OUT && $past(state_q) == ST_CALC) |-> (y_q >= y_min && y_q <= y_max)); // R6

    AST_OUT_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_OUT && $past(state_q) == ST_OUT) |-> (gpio_word == $unsigned(y_q))); // R7

    AST_FAULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(adc_fault) |-> $stable(y_q)); // R8

    AST_STOP_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_STOP) |=> (gpio_word == '0 && !adc_fault)); // R9
endmodule

bind dclink_pi_ctrl dclink_pi_chk #(.OUT_W(OUT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .run_en(run_en), .state_q(state_q), .tick(tick),
    .adc_ready(adc_ready), .adc_req(adc_req), .adc_fault(adc_fault),
    .y_q(y_q), .y_min(y_min), .y_max(y_max), .gpio_word(gpio_word)
);

// File: tb/sim_dclink_pi_ctrl.sv
module sim_dclink_pi_ctrl;
    localparam int CLK_PERIOD = 20;
    localparam int PER = 64;
    localparam int TMO = 12;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic run_en = 1'b0;
    logic [11:0] v_ref = '0;
    logic signed [15:0] kp_r = '0, ki_r = '0;
    logic signed [15:0] ymin_r = -16'sd20000, ymax_r = 16'sd20000;
    logic adc_ready = 1'b0;
    logic [11:0] code_r = '0;
    logic adc_req, adc_fault;
    logic [15:0] gpio_word;

    int n_chk = 0, n_bad = 0;
    bit done = 0;
    int resp_delay = 2;
    int age = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dclink_pi_ctrl #(.PERIOD(PER), .TIMEOUT(TMO)) u0 (
        .clk(clk), .rst_n(rst_n), .run_en(run_en), .v_ref(v_ref),
        .kp(kp_r), .ki_t(ki_r), .y_min(ymin_r), .y_max(ymax_r),
        .adc_ready(adc_ready), .adc_code(code_r),
        .adc_req(adc_req), .adc_fault(adc_fault), .gpio_word(gpio_word)
    );

    task automatic chk(input int act, input int exp, input string tag);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
        end
    endtask

    // behavioural reference: phase 0 idle, 1 acquire, 2 compute, 3 publish
    int m_cnt, m_phase, m_wait, m_samp, m_y, m_e, m_gpio, m_fault;
    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt = 0; m_phase = 0; m_wait = 0; m_samp = 0;
            m_y = 0; m_e = 0; m_gpio = 0; m_fault = 0;
        end else begin
            int nxt, e, acc, c;
            bit tk;
            tk = (m_cnt == PER - 1);
            m_cnt = tk ? 0 : m_cnt + 1;
            nxt = m_phase;
            case (m_phase)
                0: begin
                    m_y = 0; m_e = 0; m_gpio = 0; m_fault = 0;
                    if (tk) nxt = 1;
                end
                1: begin
                    if (adc_ready) begin
                        m_samp = int'(code_r); m_fault = 0; nxt = 2;
                    end else if (m_wait == TMO - 1) begin
                        m_fault = 1; nxt = 3;
                    end
                end
                2: begin
                    e = int'(v_ref) - m_samp;
                    acc = int'(kp_r) * (e - m_e) + int'(ki_r) * e;
                    c = m_y + (acc >>> 8);
                    if (c > int'(ymax_r)) c = int'(ymax_r);
                    else if (c < int'(ymin_r)) c = int'(ymin_r);
                    m_y = c; m_e = e; nxt = 3;
                end
                default: begin
                    m_gpio = m_y;
                    if (tk) nxt = 1;
                end
            endcase
            m_wait = (m_phase == 1 && !adc_ready && m_wait != TMO - 1) ? m_wait + 1 : 0;
            if (!run_en) nxt = 0;
            m_phase = nxt;
        end
    end

    // cycle-by-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk(int'(gpio_word), int'(m_gpio[15:0]), "R5 R7 gpio_word");
            chk(int'(adc_req), int'(m_phase == 1), "R4 adc_req");
            chk(int'(adc_fault), m_fault, "R8 adc_fault");
        end
    end

    // ADC responder: ready after resp_delay request cycles, never if negative
    always @(negedge clk) begin
        if (adc_req) begin
            adc_ready = (resp_delay >= 0 && age == resp_delay);
            age = age + 1;
        end else begin
            adc_ready = 1'b0;
            age = 0;
        end
    end

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog act=timeout exp=finish");
            done = 1;
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int t0, t1, g;
        wait_cyc(3);
        rst_n = 1'b1;
        wait_cyc(2);
        chk(int'(gpio_word), 0, "R1 gpio reset");
        chk(int'(adc_req), 0, "R1 req reset");
        chk(int'(adc_fault), 0, "R1 fault reset");

        wait_cyc(100);
        chk(int'(adc_req), 0, "R2 idle without run");

        v_ref = 12'd2000; code_r = 12'd1800;
        kp_r = 16'sd256; ki_r = 16'sd32;
        run_en = 1'b1;
        t0 = 0;
        while (!adc_req && t0 <= 2 * PER) begin wait_cyc(1); t0++; end
        chk(int'(t0 <= PER), 1, "R2 first request within one period");
        while (adc_req) wait_cyc(1);
        t1 = 0;
        while (!adc_req && t1 <= 2 * PER) begin wait_cyc(1); t1++; end
        while (adc_req) wait_cyc(1);
        t0 = 0;
        while (!adc_req && t0 <= 2 * PER) begin wait_cyc(1); t0++; end
        chk(t0 + (resp_delay + 1), PER, "R3 request spacing");

        for (int k = 0; k < 6; k++) begin
            code_r = 12'(1700 + 37 * k);
            wait_cyc(PER);
        end

        v_ref = 12'd4095; code_r = 12'd0; ki_r = 16'sd2048;
        wait_cyc(4 * PER);
        chk(int'($signed(gpio_word)), int'(ymax_r), "R6 clamp high");
        v_ref = 12'd0; code_r = 12'd4095;
        wait_cyc(2 * PER);
        chk(int'($signed(gpio_word)), int'(ymin_r), "R6 no windup leaves max at once");

        v_ref = 12'd2000; code_r = 12'd1900; ki_r = 16'sd32;
        wait_cyc(3 * PER);
        resp_delay = -1;
        wait_cyc(PER + TMO + 4);
        g = int'(gpio_word);
        wait_cyc(2 * PER);
        chk(int'(adc_fault), 1, "R8 timeout flag");
        chk(int'(gpio_word), g, "R8 output held");

        resp_delay = TMO - 1;
        wait_cyc(2 * PER);
        chk(int'(adc_fault), 0, "R4 ready on last cycle captured");

        resp_delay = 2;
        while (!adc_req) wait_cyc(1);
        wait_cyc(PER - 1);
        run_en = 1'b0;
        wait_cyc(1);
        chk(int'(adc_req), 0, "R9 stop beats tick");
        wait_cyc(1);
        chk(int'(gpio_word), 0, "R9 output cleared");
        chk(int'(adc_fault), 0, "R9 fault cleared");

        wait_cyc(10);
        run_en = 1'b1;
        code_r = 12'd1500;
        wait_cyc(3 * PER);

        done = 1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule